// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the two source register numbers of the instruction in decode, and at the destination number, write enable and load flag of the instructions in execute and memory. From these it works out where each ALU operand must come from once that decode instruction reaches execute. It also decides whether the front of the pipeline must hold because of a load-use dependency, and which pipeline registers must be cleared when a taken branch or jump resolves in the memory stage.

The operand-source selects are worked out one stage early and held in a register. When the decode instruction moves into execute, its selects are already waiting at the ALU input multiplexers, so the execute stage has no register-number compare in its path. The hold and clear outputs are combinational. They must act in the same cycle as the condition that causes them. The register file, ALU and memories are outside the block. The register file writes in the first half of a cycle and reads in the second half, so no writeback-to-decode bypass is needed.

Top module: `pipe_hazard_unit`

## Requirements
- R1: After a synchronous reset, both operand selects read 2'b00 (take the value from the register file).
- R2: If a decode source register is nonzero and equals the execute-stage destination while that destination's write enable is high, the matching operand select becomes 2'b01 (EX/MEM ALU result) in the following cycle. This applies when neither a hold nor a branch clear happens in the current cycle.
- R3: If a decode source register is nonzero and equals the memory-stage destination while that stage writes, the matching operand select becomes 2'b10 (MEM/WB value, load data or ALU result) in the following cycle. This applies only when the execute stage does not also match.
- R4: When both the execute and the memory stages match the same source, the younger value (2'b01) wins.
- R5: Register 0 never produces a forwarding match and never causes a hold.
- R6: A destination whose write enable is low never matches. Stores and branches have their write enable low.
- R7: A load in execute whose nonzero destination equals either decode source raises hold_front and squash_idex in that same cycle. Both operand selects read 2'b00 in the next cycle. The hold lasts exactly one cycle, because the load has moved on to memory by then.
- R8: A taken branch or jump in memory raises squash_ifid, squash_idex and squash_exmem in the same cycle and forces hold_front low, even if a load-use condition is also present. Both selects read 2'b00 in the next cycle.
- R9: The two operands are resolved independently. Each can have a different source in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| ex_rd | input | REG_AW | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| br_taken_mem | input | 1 | Taken branch or jump resolved in memory |
| fwd_a_sel | output | 2 | Source of ALU operand A in execute (00 file, 01 EX/MEM, 10 MEM/WB) |
| fwd_b_sel | output | 2 | Source of ALU operand B in execute (same encoding) |
| hold_front | output | 1 | Hold the PC and the IF/ID register |
| squash_ifid | output | 1 | Clear the IF/ID register |
| squash_idex | output | 1 | Load a bubble into the ID/EX register |
| squash_exmem | output | 1 | Clear the EX/MEM register |

## Verification
The stored selects are the only internal state. A wrong value there appears on fwd_a_sel or fwd_b_sel exactly one cycle after the decode inputs that caused it, so each check is sampled in the cycle after its stimulus. A select that fails to return to 2'b00 after a bubble or a branch clear shows up as a stale forward in the cycle right after the hold or clear. The bench drives a load-use hold followed by its release, a branch that coincides with a load-use case, and cases where both stages match.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
  localparam int NUM_OPERANDS = 2;

  typedef enum logic [1:0] {
    FWD_NONE  = 2'b00,
    FWD_EXMEM = 2'b01,
    FWD_MEMWB = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/hzu_operand_match.sv
module hzu_operand_match
  import hzu_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rs,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  output fwd_src_e      next_src,
  output logic          ex_hit
);
  logic rs_live;
  logic mem_hit;

  always_comb begin
    rs_live = (rs != '0);
    ex_hit  = rs_live && ex_wen && (ex_rd == rs);
    mem_hit = rs_live && mem_wen && (mem_rd == rs);
    // the younger producer wins
    if (ex_hit)       next_src = FWD_EXMEM;
    else if (mem_hit) next_src = FWD_MEMWB;
    else              next_src = FWD_NONE;
  end
endmodule

// File: rtl/hzu_ctrl.sv
module hzu_ctrl #(
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0] ex_hit,
  input  logic            ex_is_load,
  input  logic            br_taken,
  output logic            hold,
  output logic            clr_ifid,
  output logic            clr_idex,
  output logic            clr_exmem
);
  logic load_use;

  always_comb begin
    load_use  = ex_is_load && (|ex_hit);
    // a redirect makes the waiting instruction irrelevant
    hold      = load_use && !br_taken;
    clr_ifid  = br_taken;
    clr_idex  = br_taken || load_use;
    clr_exmem = br_taken;
  end
endmodule

// File: rtl/hzu_sel_reg.sv
module hzu_sel_reg
  import hzu_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     kill,
  input  fwd_src_e d [NSRC],
  output fwd_src_e q [NSRC]
);
  for (genvar g = 0; g < NSRC; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst || kill) q[g] <= FWD_NONE;
      else             q[g] <= d[g];
    end
  end
endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hzu_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_wen,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_wen,
  input  logic              br_taken_mem,
  output logic [1:0]        fwd_a_sel,
  output logic [1:0]        fwd_b_sel,
  output logic              hold_front,
  output logic              squash_ifid,
  output logic              squash_idex,
  output logic              squash_exmem
);
  localparam int NSRC = NUM_OPERANDS;

  logic [REG_AW-1:0] src_id [NSRC];
  fwd_src_e          nxt_src [NSRC];
  fwd_src_e          cur_src [NSRC];
  logic [NSRC-1:0]   ex_hit;

  assign src_id[0] = id_rs1;
  assign src_id[1] = id_rs2;

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    hzu_operand_match #(.AW(REG_AW)) u_match (
      .rs       (src_id[g]),
      .ex_rd    (ex_rd),
      .ex_wen   (ex_wen),
      .mem_rd   (mem_rd),
      .mem_wen  (mem_wen),
      .next_src (nxt_src[g]),
      .ex_hit   (ex_hit[g])
    );
  end

  hzu_ctrl #(.NSRC(NSRC)) u_ctrl (
    .ex_hit     (ex_hit),
    .ex_is_load (ex_is_load),
    .br_taken   (br_taken_mem),
    .hold       (hold_front),
    .clr_ifid   (squash_ifid),
    .clr_idex   (squash_idex),
    .clr_exmem  (squash_exmem)
  );

  // a bubble entering execute carries no forwarding
  hzu_sel_reg #(.NSRC(NSRC)) u_sel (
    .clk  (clk),
    .rst  (rst),
    .kill (squash_idex),
    .d    (nxt_src),
    .q    (cur_src)
  );

  assign fwd_a_sel = cur_src[0];
  assign fwd_b_sel = cur_src[1];
endmodule

// File: rtl/pipe_hazard_unit_chk.sv
module pipe_hazard_unit_chk #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] id_rs1,
  input logic [AW-1:0] id_rs2,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_is_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic          br_taken_mem,
  input logic [1:0]    fwd_a_sel,
  input logic [1:0]    fwd_b_sel,
  input logic          hold_front,
  input logic          squash_ifid,
  input logic          squash_idex,
  input logic          squash_exmem
);
  // R8
  br_clears_all_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken_mem |-> (squash_ifid && squash_idex && squash_exmem && !hold_front));

  // R7
  load_use_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_is_load && ex_wen && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2) && !br_taken_mem)
      |-> (hold_front && squash_idex && !squash_ifid && !squash_exmem));

  // R7
  hold_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
    hold_front |-> ex_is_load);

  // R5
  zero_dest_no_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_rd == '0) |-> !hold_front);

  // R2
  exmem_fwd_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!squash_idex && ex_wen && ex_rd != '0 && ex_rd == id_rs1) |=> (fwd_a_sel == 2'b01));

  // R3
  memwb_fwd_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!squash_idex && mem_wen && mem_rd != '0 && mem_rd == id_rs2 && !(ex_wen && ex_rd == id_rs2))
      |=> (fwd_b_sel == 2'b10));

  // R8
  bubble_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    squash_idex |=> (fwd_a_sel == 2'b00 && fwd_b_sel == 2'b00));

  // R9
  sel_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_a_sel != 2'b11 && fwd_b_sel != 2'b11));
endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk #(.AW(REG_AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .id_rs1       (id_rs1),
  .id_rs2       (id_rs2),
  .ex_rd        (ex_rd),
  .ex_wen       (ex_wen),
  .ex_is_load   (ex_is_load),
  .mem_rd       (mem_rd),
  .mem_wen      (mem_wen),
  .br_taken_mem (br_taken_mem),
  .fwd_a_sel    (fwd_a_sel),
  .fwd_b_sel    (fwd_b_sel),
  .hold_front   (hold_front),
  .squash_ifid  (squash_ifid),
  .squash_idex  (squash_idex),
  .squash_exmem (squash_exmem)
);

// File: tb/pipe_hazard_unit_tb.sv
`timescale 1ns/1ps
module pipe_hazard_unit_tb;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
  logic          ex_wen = 1'b0, ex_is_load = 1'b0, mem_wen = 1'b0, br_taken_mem = 1'b0;
  logic [1:0]    fwd_a_sel, fwd_b_sel;
  logic          hold_front, squash_ifid, squash_idex, squash_exmem;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  logic [3:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  pipe_hazard_unit #(.REG_AW(AW)) u_dut (
    .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .br_taken_mem(br_taken_mem),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .hold_front(hold_front),
    .squash_ifid(squash_ifid), .squash_idex(squash_idex), .squash_exmem(squash_exmem)
  );

  task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] want_src(logic [AW-1:0] rs);
    if (rs != '0 && ex_wen && ex_rd == rs)   return 2'b01;
    if (rs != '0 && mem_wen && mem_rd == rs) return 2'b10;
    return 2'b00;
  endfunction

  // driver: apply one cycle of stage state, check same-cycle controls,
  // queue the operand sources expected one cycle later
  task automatic drive(string req, logic [AW-1:0] r1, logic [AW-1:0] r2,
                       logic [AW-1:0] erd, logic ew, logic eld,
                       logic [AW-1:0] mrd, logic mw, logic br);
    logic lu, kill;
    @(negedge clk);
    id_rs1 = r1; id_rs2 = r2; ex_rd = erd; ex_wen = ew; ex_is_load = eld;
    mem_rd = mrd; mem_wen = mw; br_taken_mem = br;
    #1;
    lu   = eld && ew && erd != '0 && (erd == r1 || erd == r2);
    kill = lu || br;
    check(req, "hold_front",   {1'b0, hold_front},   {1'b0, lu && !br});
    check(req, "squash_ifid",  {1'b0, squash_ifid},  {1'b0, br});
    check(req, "squash_idex",  {1'b0, squash_idex},  {1'b0, kill});
    check(req, "squash_exmem", {1'b0, squash_exmem}, {1'b0, br});
    exp_q.push_back(kill ? 4'b0000 : {want_src(r1), want_src(r2)});
    tag_q.push_back(req);
  endtask

  // monitor: compare registered selects one cycle after each drive
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      logic [3:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, "fwd_a_sel", fwd_a_sel, e[3:2]);
      check(t, "fwd_b_sel", fwd_b_sel, e[1:0]);
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog all-reqs actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1", "fwd_a_sel", fwd_a_sel, 2'b00);
    check("R1", "fwd_b_sel", fwd_b_sel, 2'b00);
    check("R1", "hold_front", {1'b0, hold_front}, 2'b00);

    drive("R2", 5'd3, 5'd9, 5'd3, 1, 0, 5'd0, 0, 0);
    drive("R2", 5'd1, 5'd7, 5'd7, 1, 0, 5'd2, 1, 0);
    drive("R3", 5'd4, 5'd8, 5'd1, 1, 0, 5'd4, 1, 0);
    drive("R4", 5'd5, 5'd5, 5'd5, 1, 0, 5'd5, 1, 0);
    drive("R5", 5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1, 0);
    drive("R6", 5'd6, 5'd6, 5'd6, 0, 0, 5'd6, 0, 0);
    drive("R6", 5'd11, 5'd12, 5'd12, 0, 1, 5'd11, 0, 0);
    // R7 load-use: hold, then the load sits in memory and is forwarded
    drive("R7", 5'd2, 5'd6, 5'd6, 1, 1, 5'd0, 0, 0);
    drive("R7", 5'd2, 5'd6, 5'd0, 0, 0, 5'd6, 1, 0);
    drive("R7", 5'd13, 5'd14, 5'd15, 1, 1, 5'd14, 1, 0);
    // R8 branch clears everything and overrides a load-use hold
    drive("R8", 5'd10, 5'd3, 5'd10, 1, 1, 5'd3, 1, 1);
    drive("R8", 5'd20, 5'd21, 5'd20, 1, 0, 5'd21, 1, 1);
    drive("R9", 5'd17, 5'd18, 5'd17, 1, 0, 5'd18, 1, 0);
    drive("R9", 5'd31, 5'd30, 5'd30, 1, 0, 5'd31, 1, 0);
    drive("R1", 5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 0);

    while (exp_q.size() > 0) @(negedge clk);
    #1;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule